// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block decides the outcome of a request to load one of the data or stack segment registers while the processor runs in protected or 64-bit mode. Each request carries the target register, a 16-bit selector, the current privilege level (CPL) and the attributes of the descriptor that the selector points to. The descriptor has already been fetched by other logic, which also reports whether the selector index lies beyond the descriptor table limit.

One cycle after the request, the block reports exactly one result. It either raises a commit strobe, which carries the selector and the descriptor attributes to be latched into the target register, or it raises a fault with a class (general protection, stack, not present or invalid opcode) and an error code. The target register decides which checks run and in what order. A selector value of 0 to 3 counts as null and is treated differently for the stack register than for the data registers. A successful stack segment load also opens an interrupt-inhibit window, which lasts until the instruction after the load has retired.

Top module: `seg_load_checker`

## Requirements
- R1: After reset, commit_valid, fault_valid and irq_inhibit are all 0.
- R2: A request sampled on a rising edge produces, after that same edge, exactly one of commit_valid or fault_valid for one cycle. No output strobe appears in a cycle without a request. A commit carries the selector and commit_attr = {present, DPL, type}.
- R3: Targets are encoded 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS. Target CS, or any code of 6 or 7, gives a fault of class UD (4) with error code 0.
- R4: desc_type bit 4 is set for a code or data descriptor (clear for a system descriptor), bit 3 set means code, bit 2 means conforming for code, and bit 1 means readable for code or writable for data. Fault classes are encoded 1=GP, 2=SS, 3=NP, 4=UD.
- R5: A null selector (value 0 to 3) loaded into ES, DS, FS or GS commits, whatever the limit flag and descriptor attributes are, including not present.
- R6: A null selector loaded into SS outside 64-bit mode gives GP with code 0. In 64-bit mode it gives GP with code 0 when CPL is 3 or when RPL differs from CPL, and commits otherwise.
- R7: A non-null SS load gives GP if the limit is exceeded, RPL differs from CPL, the descriptor is not a writable data segment, or DPL differs from CPL. Every error code that carries a selector is that selector with bits 1:0 cleared.
- R8: A non-null SS load that passes R7 but whose descriptor is not present gives a fault of class SS carrying the selector.
- R9: A non-null ES/DS/FS/GS load gives GP carrying the selector if the limit is exceeded, or if the descriptor is neither a data segment nor a readable code segment.
- R10: A non-null ES/DS/FS/GS load of a data or nonconforming code segment gives GP carrying the selector when both RPL and CPL are greater than DPL. Conforming code is exempt from this check.
- R11: A non-null ES/DS/FS/GS load that passes R9 and R10 but is not present gives NP carrying the selector.
- R12: All general-protection checks take priority over the present check, so only the first failing check is reported.
- R13: irq_inhibit rises together with the commit of an SS load. It stays high through the first retire pulse, which is the retirement of the loading instruction, and falls after the second retire pulse. A failed SS load does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present this cycle |
| req_target | input | 3 | Target segment register code |
| req_sel | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | 1 when running in 64-bit mode |
| lim_exceed | input | 1 | Selector index lies beyond the table limit |
| desc_type | input | 5 | Descriptor class and type bits |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present bit |
| retire | input | 1 | One-cycle instruction retirement pulse |
| commit_valid | output | 1 | Load accepted |
| commit_target | output | 3 | Register to update |
| commit_sel | output | 16 | Selector to latch |
| commit_attr | output | 8 | {present, DPL, type} to latch |
| fault_valid | output | 1 | Load refused |
| fault_class | output | 3 | Fault class code |
| fault_code | output | 16 | Error code |
| irq_inhibit | output | 1 | Interrupts held off |

## Verification
The bench targets the asymmetric null handling. A design that applied the stack rule to data registers would fault on a harmless null DS load, and one that ignored 64-bit mode would reject a legal null SS load. It checks that a stack load with a bad limit and a missing descriptor reports GP rather than SS, since swapping the order of those checks would report the wrong fault. It also covers the privilege exemption for conforming readable code, and cases where only one of RPL or CPL exceeds DPL, which a design that used OR instead of AND would wrongly refuse. Finally it counts retire pulses against irq_inhibit, so a window that closed on the loading instruction's own retirement is caught.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  localparam int SEL_W  = 16;
  localparam int TYPE_W = 5;
  localparam int PL_W   = 2;
  localparam int ATTR_W = TYPE_W + PL_W + 1;

  localparam logic [2:0] TGT_ES = 3'd0;
  localparam logic [2:0] TGT_CS = 3'd1;
  localparam logic [2:0] TGT_SS = 3'd2;
  localparam logic [2:0] TGT_DS = 3'd3;
  localparam logic [2:0] TGT_FS = 3'd4;
  localparam logic [2:0] TGT_GS = 3'd5;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_GP   = 3'd1,
    FC_SS   = 3'd2,
    FC_NP   = 3'd3,
    FC_UD   = 3'd4
  } fclass_e;

  // descriptor type bit positions
  localparam int TB_CODEDATA = 4;
  localparam int TB_CODE     = 3;
  localparam int TB_CONF     = 2;
  localparam int TB_RW       = 1;

  function automatic logic tgt_is_data_reg(input logic [2:0] t);
    return (t == TGT_ES) || (t == TGT_DS) || (t == TGT_FS) || (t == TGT_GS);
  endfunction

  function automatic logic ty_data(input logic [TYPE_W-1:0] ty);
    return ty[TB_CODEDATA] && !ty[TB_CODE];
  endfunction

  function automatic logic ty_writable_data(input logic [TYPE_W-1:0] ty);
    return ty_data(ty) && ty[TB_RW];
  endfunction

  function automatic logic ty_readable_code(input logic [TYPE_W-1:0] ty);
    return ty[TB_CODEDATA] && ty[TB_CODE] && ty[TB_RW];
  endfunction

  function automatic logic ty_nonconf_code(input logic [TYPE_W-1:0] ty);
    return ty[TB_CODEDATA] && ty[TB_CODE] && !ty[TB_CONF];
  endfunction

endpackage

// File: rtl/seg_sel_fields.sv
module seg_sel_fields #(
  parameter int SEL_W = 16,
  parameter int PL_W  = 2
) (
  input  logic [SEL_W-1:0] sel,
  output logic             sel_null,
  output logic [PL_W-1:0]  sel_rpl,
  output logic [SEL_W-1:0] sel_err
);
  localparam int IDX_W = SEL_W - PL_W;

  assign sel_rpl  = sel[PL_W-1:0];
  assign sel_null = (sel[SEL_W-1:PL_W] == '0);
  assign sel_err  = {sel[SEL_W-1:PL_W], {PL_W{1'b0}}};

  initial begin
    assert (IDX_W > 0) else $error("selector too narrow");
  end
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
  import segchk_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int TYPE_W = 5,
  parameter int PL_W   = 2
) (
  input  logic [2:0]        target,
  input  logic              sel_null,
  input  logic [PL_W-1:0]   rpl,
  input  logic [PL_W-1:0]   cpl,
  input  logic              long_mode,
  input  logic              lim_exceed,
  input  logic [TYPE_W-1:0] dtype,
  input  logic [PL_W-1:0]   dpl,
  input  logic              present,
  output fclass_e           fclass,
  output logic              code_uses_sel,
  output logic              gp_stack_hit,
  output logic              gp_data_hit,
  output logic              priv_hit
);
  localparam logic [PL_W-1:0] PL_MAX = '1;

  logic ss_null_bad;

  always_comb begin
    priv_hit     = (ty_data(dtype) || ty_nonconf_code(dtype)) &&
                   (rpl > dpl) && (cpl > dpl);
    gp_stack_hit = lim_exceed || (rpl != cpl) ||
                   !ty_writable_data(dtype) || (dpl != cpl);
    gp_data_hit  = lim_exceed ||
                   !(ty_data(dtype) || ty_readable_code(dtype)) || priv_hit;
    ss_null_bad  = !long_mode || (cpl == PL_MAX) || (rpl != cpl);
  end

  always_comb begin
    fclass        = FC_NONE;
    code_uses_sel = 1'b0;
    if (target == TGT_SS) begin
      if (sel_null) begin
        if (ss_null_bad) fclass = FC_GP;
      end else if (gp_stack_hit) begin
        fclass        = FC_GP;
        code_uses_sel = 1'b1;
      end else if (!present) begin
        fclass        = FC_SS;
        code_uses_sel = 1'b1;
      end
    end else if (tgt_is_data_reg(target)) begin
      if (!sel_null) begin
        if (gp_data_hit) begin
          fclass        = FC_GP;
          code_uses_sel = 1'b1;
        end else if (!present) begin
          fclass        = FC_NP;
          code_uses_sel = 1'b1;
        end
      end
    end else begin
      fclass = FC_UD;
    end
  end
endmodule

// File: rtl/seg_irq_shadow.sv
module seg_irq_shadow (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_commit,
  input  logic retire,
  output logic inhibit
);
  typedef enum logic [1:0] {SH_IDLE, SH_ARMED, SH_SHADOW} sh_state_e;

  sh_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ss_commit) begin
      state_d = SH_ARMED;
    end else if (retire) begin
      unique case (state_q)
        SH_ARMED:  state_d = SH_SHADOW;
        SH_SHADOW: state_d = SH_IDLE;
        default:   state_d = SH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SH_IDLE;
    else        state_q <= state_d;
  end

  assign inhibit = (state_q != SH_IDLE);

  // R13: the window only opens on a stack segment commit
  p_inhibit_opens_on_ss_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |-> $past(ss_commit));

  // R13: the second retire closes the window
  p_second_retire_closes_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_SHADOW) && retire && !ss_commit |=> !inhibit);

  // R13: the loading instruction's own retire keeps the window open
  p_first_retire_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_ARMED) && retire |=> inhibit);
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import segchk_pkg::*;
#(
  parameter int SEL_W  = segchk_pkg::SEL_W,
  parameter int TYPE_W = segchk_pkg::TYPE_W,
  parameter int PL_W   = segchk_pkg::PL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [2:0]                 req_target,
  input  logic [SEL_W-1:0]           req_sel,
  input  logic [PL_W-1:0]            cpl,
  input  logic                       long_mode,
  input  logic                       lim_exceed,
  input  logic [TYPE_W-1:0]          desc_type,
  input  logic [PL_W-1:0]            desc_dpl,
  input  logic                       desc_present,
  input  logic                       retire,
  output logic                       commit_valid,
  output logic [2:0]                 commit_target,
  output logic [SEL_W-1:0]           commit_sel,
  output logic [TYPE_W+PL_W:0]       commit_attr,
  output logic                       fault_valid,
  output logic [2:0]                 fault_class,
  output logic [SEL_W-1:0]           fault_code,
  output logic                       irq_inhibit
);
  localparam int AW = TYPE_W + PL_W + 1;

  logic             sel_null;
  logic [PL_W-1:0]  sel_rpl;
  logic [SEL_W-1:0] sel_err;
  fclass_e          fclass;
  logic             code_uses_sel;
  logic             gp_stack_hit, gp_data_hit, priv_hit;
  logic             accept_now, refuse_now, ss_commit_now;

  seg_sel_fields #(.SEL_W(SEL_W), .PL_W(PL_W)) u_fields (
    .sel      (req_sel),
    .sel_null (sel_null),
    .sel_rpl  (sel_rpl),
    .sel_err  (sel_err)
  );

  seg_rule_eval #(.SEL_W(SEL_W), .TYPE_W(TYPE_W), .PL_W(PL_W)) u_rules (
    .target        (req_target),
    .sel_null      (sel_null),
    .rpl           (sel_rpl),
    .cpl           (cpl),
    .long_mode     (long_mode),
    .lim_exceed    (lim_exceed),
    .dtype         (desc_type),
    .dpl           (desc_dpl),
    .present       (desc_present),
    .fclass        (fclass),
    .code_uses_sel (code_uses_sel),
    .gp_stack_hit  (gp_stack_hit),
    .gp_data_hit   (gp_data_hit),
    .priv_hit      (priv_hit)
  );

  assign accept_now    = req_valid && (fclass == FC_NONE);
  assign refuse_now    = req_valid && (fclass != FC_NONE);
  assign ss_commit_now = accept_now && (req_target == TGT_SS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_valid  <= 1'b0;
      commit_target <= '0;
      commit_sel    <= '0;
      commit_attr   <= '0;
      fault_valid   <= 1'b0;
      fault_class   <= FC_NONE;
      fault_code    <= '0;
    end else begin
      commit_valid  <= accept_now;
      commit_target <= accept_now ? req_target : '0;
      commit_sel    <= accept_now ? req_sel : '0;
      commit_attr   <= accept_now ? AW'({desc_present, desc_dpl, desc_type}) : '0;
      fault_valid   <= refuse_now;
      fault_class   <= refuse_now ? fclass : FC_NONE;
      fault_code    <= (refuse_now && code_uses_sel) ? sel_err : '0;
    end
  end

  seg_irq_shadow u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .ss_commit (ss_commit_now),
    .retire    (retire),
    .inhibit   (irq_inhibit)
  );

  // R2: one outcome per request, never both
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_valid && fault_valid));

  // R2: no strobe without a request
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !commit_valid && !fault_valid);

  // R3: code-segment loads are refused as invalid opcode
  p_cs_is_ud_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_target == TGT_CS) |=> fault_valid && (fault_class == FC_UD) && (fault_code == '0));

  // R5: null into a data register always commits
  p_null_data_commits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && tgt_is_data_reg(req_target) && (req_sel[SEL_W-1:PL_W] == '0) |=> commit_valid);

  // R6: null stack load outside 64-bit mode is GP(0)
  p_null_ss_legacy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_target == TGT_SS) && !long_mode && (req_sel[SEL_W-1:PL_W] == '0)
    |=> fault_valid && (fault_class == FC_GP) && (fault_code == '0));

  // R8: stack faults only come from stack loads; R11: not-present only from data loads
  p_ss_class_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_target != TGT_SS) |=> !(fault_valid && (fault_class == FC_SS)));

  // R12: a GP condition on a stack load wins over the present bit
  p_gp_before_present_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_target == TGT_SS) && !sel_null && gp_stack_hit
    |=> fault_class == FC_GP);
endmodule

// File: tb/tb_seg_load_checker.sv
module tb_seg_load_checker;
  import segchk_pkg::*;

  typedef struct {
    logic        is_commit;
    logic [2:0]  cls;
    logic [15:0] code;
    logic [2:0]  tgt;
    logic [15:0] sel;
    logic [7:0]  attr;
    string       tag;
  } exp_t;

  localparam logic [4:0] T_DATA_RW = 5'b10010;
  localparam logic [4:0] T_DATA_RO = 5'b10000;
  localparam logic [4:0] T_CODE_RX = 5'b11010;
  localparam logic [4:0] T_CODE_XO = 5'b11000;
  localparam logic [4:0] T_CODE_CR = 5'b11110;
  localparam logic [4:0] T_SYSTEM  = 5'b00010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_target = '0;
  logic [15:0] req_sel = '0;
  logic [1:0] cpl = '0;
  logic long_mode = 1'b0;
  logic lim_exceed = 1'b0;
  logic [4:0] desc_type = '0;
  logic [1:0] desc_dpl = '0;
  logic desc_present = 1'b0;
  logic retire = 1'b0;
  logic commit_valid, fault_valid, irq_inhibit;
  logic [2:0] commit_target, fault_class;
  logic [15:0] commit_sel, fault_code;
  logic [7:0] commit_attr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  seg_load_checker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
    .req_sel(req_sel), .cpl(cpl), .long_mode(long_mode), .lim_exceed(lim_exceed),
    .desc_type(desc_type), .desc_dpl(desc_dpl), .desc_present(desc_present),
    .retire(retire), .commit_valid(commit_valid), .commit_target(commit_target),
    .commit_sel(commit_sel), .commit_attr(commit_attr), .fault_valid(fault_valid),
    .fault_class(fault_class), .fault_code(fault_code), .irq_inhibit(irq_inhibit)
  );

  task automatic check(input bit ok, input string tag, input string got, input string want);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, got, want);
    end
  endtask

  // Reference model written as an ordered list of refusals
  function automatic exp_t model(input logic [2:0] t, input logic [15:0] s, input logic [1:0] c,
                                 input logic lm, input logic lim, input logic [4:0] ty,
                                 input logic [1:0] d, input logic p, input string tag);
    exp_t e;
    logic isnull, dataseg, rcode, ncode;
    logic [1:0] r;
    r = s[1:0];
    isnull = (s < 16'd4);
    dataseg = (ty[4:3] == 2'b10);
    rcode = (ty[4:3] == 2'b11) && ty[1];
    ncode = (ty[4:3] == 2'b11) && !ty[2];
    e.tag = tag; e.is_commit = 1'b0; e.cls = 3'd0; e.code = 16'h0;
    e.tgt = t; e.sel = s; e.attr = {p, d, ty};
    if (t == 3'd1 || t > 3'd5) e.cls = 3'd4;
    else if (t == 3'd2) begin
      if (isnull) begin
        if (lm && c != 2'd3 && r == c) e.is_commit = 1'b1;
        else e.cls = 3'd1;
      end else if (lim || r != c || ty != (ty | 5'b10010) || ty[3] || d != c) begin
        e.cls = 3'd1; e.code = s & 16'hFFFC;
      end else if (!p) begin
        e.cls = 3'd2; e.code = s & 16'hFFFC;
      end else e.is_commit = 1'b1;
    end else begin
      if (isnull) e.is_commit = 1'b1;
      else if (lim || !(dataseg || rcode) || ((dataseg || ncode) && r > d && c > d)) begin
        e.cls = 3'd1; e.code = s & 16'hFFFC;
      end else if (!p) begin
        e.cls = 3'd3; e.code = s & 16'hFFFC;
      end else e.is_commit = 1'b1;
    end
    return e;
  endfunction

  task automatic load(input logic [2:0] t, input logic [15:0] s, input logic [1:0] c,
                      input logic lm, input logic lim, input logic [4:0] ty,
                      input logic [1:0] d, input logic p, input string tag);
    @(posedge clk); #5;
    req_valid = 1'b1; req_target = t; req_sel = s; cpl = c; long_mode = lm;
    lim_exceed = lim; desc_type = ty; desc_dpl = d; desc_present = p;
    sb.push_back(model(t, s, c, lm, lim, ty, d, p, tag));
    @(posedge clk); #5;
    req_valid = 1'b0;
  endtask

  task automatic pulse_retire();
    @(posedge clk); #5; retire = 1'b1;
    @(posedge clk); #5; retire = 1'b0;
  endtask

  // Monitor: compare every result strobe with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && (commit_valid || fault_valid)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", $sformatf("strobe c=%b f=%b", commit_valid, fault_valid), "no strobe");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.is_commit) begin
          check(commit_valid && !fault_valid && commit_target == e.tgt &&
                commit_sel == e.sel && commit_attr == e.attr, e.tag,
                $sformatf("c=%b f=%b cls=%0d tgt=%0d sel=%h attr=%h", commit_valid, fault_valid,
                          fault_class, commit_target, commit_sel, commit_attr),
                $sformatf("commit tgt=%0d sel=%h attr=%h", e.tgt, e.sel, e.attr));
        end else begin
          check(fault_valid && !commit_valid && fault_class == e.cls && fault_code == e.code, e.tag,
                $sformatf("c=%b f=%b cls=%0d code=%h", commit_valid, fault_valid, fault_class, fault_code),
                $sformatf("fault cls=%0d code=%h", e.cls, e.code));
        end
      end
    end
  end

  initial begin
    #150000;
    if (!done) begin
      check(1'b0, "watchdog", "timeout", "finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!commit_valid && !fault_valid && !irq_inhibit, "R1",
          $sformatf("c=%b f=%b i=%b", commit_valid, fault_valid, irq_inhibit), "all 0");

    // R13 interrupt shadow after a good stack load
    load(3'd2, 16'h0020, 2'd0, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b1, "R13 ss commit");
    @(negedge clk);
    check(irq_inhibit, "R13", $sformatf("%b", irq_inhibit), "1 after SS commit");
    pulse_retire();
    @(negedge clk);
    check(irq_inhibit, "R13", $sformatf("%b", irq_inhibit), "1 after first retire");
    pulse_retire();
    @(negedge clk);
    check(!irq_inhibit, "R13", $sformatf("%b", irq_inhibit), "0 after second retire");
    load(3'd2, 16'h0020, 2'd0, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b0, "R13 ss fault");
    @(negedge clk);
    check(!irq_inhibit, "R13", $sformatf("%b", irq_inhibit), "0 after failed SS load");

    // R2 idle cycles give no strobes
    repeat (3) begin
      @(negedge clk);
      check(!commit_valid && !fault_valid, "R2", $sformatf("c=%b f=%b", commit_valid, fault_valid), "0 0");
    end

    // R3 invalid targets
    load(3'd1, 16'h0008, 2'd0, 1'b0, 1'b0, T_CODE_RX, 2'd0, 1'b1, "R3 cs");
    load(3'd7, 16'h0010, 2'd0, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b1, "R3 code7");
    // R5 null into data registers
    load(3'd3, 16'h0000, 2'd3, 1'b0, 1'b1, T_SYSTEM, 2'd0, 1'b0, "R5 ds null");
    load(3'd5, 16'h0003, 2'd0, 1'b1, 1'b0, T_CODE_XO, 2'd2, 1'b0, "R5 gs null");
    // R6 null stack loads
    load(3'd2, 16'h0000, 2'd0, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b1, "R6 ss null legacy");
    load(3'd2, 16'h0000, 2'd0, 1'b1, 1'b0, T_DATA_RW, 2'd0, 1'b1, "R6 ss null 64 ok");
    load(3'd2, 16'h0003, 2'd3, 1'b1, 1'b0, T_DATA_RW, 2'd3, 1'b1, "R6 ss null 64 cpl3");
    load(3'd2, 16'h0001, 2'd0, 1'b1, 1'b0, T_DATA_RW, 2'd0, 1'b1, "R6 ss null 64 rpl");
    // R7 stack GP conditions
    load(3'd2, 16'h0010, 2'd0, 1'b0, 1'b1, T_DATA_RW, 2'd0, 1'b1, "R7 ss limit");
    load(3'd2, 16'h0013, 2'd0, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b1, "R7 ss rpl");
    load(3'd2, 16'h0018, 2'd0, 1'b0, 1'b0, T_DATA_RO, 2'd0, 1'b1, "R7 ss readonly");
    load(3'd2, 16'h0018, 2'd0, 1'b0, 1'b0, T_CODE_RX, 2'd0, 1'b1, "R7 ss code");
    load(3'd2, 16'h001A, 2'd2, 1'b0, 1'b0, T_DATA_RW, 2'd1, 1'b1, "R7 ss dpl");
    // R8 stack not present, R12 priority
    load(3'd2, 16'h0019, 2'd1, 1'b0, 1'b0, T_DATA_RW, 2'd1, 1'b0, "R8 ss absent");
    load(3'd2, 16'h0018, 2'd0, 1'b0, 1'b1, T_DATA_RW, 2'd0, 1'b0, "R12 ss limit+absent");
    load(3'd2, 16'h0023, 2'd3, 1'b0, 1'b0, T_DATA_RW, 2'd3, 1'b1, "R2 ss commit");
    // R9 data-register GP
    load(3'd3, 16'h0028, 2'd0, 1'b0, 1'b1, T_DATA_RW, 2'd0, 1'b1, "R9 ds limit");
    load(3'd0, 16'h0028, 2'd0, 1'b0, 1'b0, T_CODE_XO, 2'd0, 1'b1, "R9 es exec-only");
    load(3'd4, 16'h0028, 2'd0, 1'b0, 1'b0, T_SYSTEM, 2'd0, 1'b1, "R9 fs system");
    load(3'd3, 16'h0030, 2'd0, 1'b0, 1'b0, T_DATA_RO, 2'd0, 1'b1, "R9 ds readonly data ok");
    // R10 privilege
    load(3'd3, 16'h0033, 2'd3, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b1, "R10 both above");
    load(3'd3, 16'h0033, 2'd0, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b1, "R10 rpl only");
    load(3'd0, 16'h0030, 2'd3, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b1, "R10 cpl only");
    load(3'd4, 16'h0032, 2'd2, 1'b0, 1'b0, T_CODE_RX, 2'd1, 1'b1, "R10 nonconf code");
    load(3'd5, 16'h0033, 2'd3, 1'b0, 1'b0, T_CODE_CR, 2'd0, 1'b1, "R10 conforming exempt");
    // R11 not present, R12 priority
    load(3'd5, 16'h0040, 2'd0, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b0, "R11 gs absent");
    load(3'd0, 16'h0043, 2'd3, 1'b0, 1'b0, T_DATA_RW, 2'd0, 1'b0, "R12 es priv+absent");
    // R4 back-to-back requests
    @(posedge clk); #5;
    req_valid = 1'b1; req_target = 3'd4; req_sel = 16'h0048; cpl = 2'd0; long_mode = 1'b0;
    lim_exceed = 1'b0; desc_type = T_CODE_RX; desc_dpl = 2'd0; desc_present = 1'b1;
    sb.push_back(model(3'd4, 16'h0048, 2'd0, 1'b0, 1'b0, T_CODE_RX, 2'd0, 1'b1, "R4 b2b a"));
    @(posedge clk); #5;
    desc_type = T_CODE_XO;
    sb.push_back(model(3'd4, 16'h0048, 2'd0, 1'b0, 1'b0, T_CODE_XO, 2'd0, 1'b1, "R4 b2b b"));
    @(posedge clk); #5;
    req_valid = 1'b0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R2", $sformatf("%0d pending", sb.size()), "0 pending");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule